// File: doc/BRIEF.md
# Predictor-Directed Prefetch Stream Buffer Array

This block is a set of prefetch stream buffers placed beside an L1 data cache. A buffer is claimed by one load, named by its program counter. The claiming request also loads the buffer with that load's last address and stride. The buffer does not work out its own next addresses. Each empty slot asks an outside address predictor through a request/response port. The buffer offers the predictor its owning PC, the address it last predicted and its stride. In return the predictor hands back the next address. Because of this split, any predictor design can steer the buffers.

A slot that holds a predicted address offers a prefetch to the next memory level through a port that takes one request per cycle. The returning line is tagged with its buffer and slot numbers. Each L1 load access is compared against every slot at once. A hit on a slot whose line has arrived returns the line in the same cycle and frees the slot. A hit on a slot whose prefetch is still in flight is reported as hit-pending. A probe input can discard predicted slots that are no longer worth fetching, but only in cycles when the prefetch port is not in use.

Top module: `pdsb_array`

## Requirements
- R1: While reset is held, and right after it, no buffer is owned: `pred_req_valid` and `pf_valid` are 0, and every lookup misses (`lk_hit` = 0, `lk_pend` = 0).
- R2: An accepted allocation goes to the lowest-numbered buffer that has no owner. That buffer takes the PC, last address and stride given with the request, and all of its slots become empty.
- R3: An allocation whose PC equals the PC of a buffer already owned is ignored. That buffer keeps its last address and stride.
- R4: When every buffer is owned, an allocation replaces a victim buffer. Victims are chosen in rotation starting at buffer 0. Everything the victim held, including predicted and in-flight slots, is discarded.
- R5: `pred_req_valid` is 1 while any owned buffer has an empty slot. The request shows the lowest such buffer, with its PC, last address and stride. On a handshake (`pred_req_valid` and `pred_ready`), the lowest empty slot of that buffer takes `pred_addr` and becomes predicted. The buffer's last address then becomes `pred_addr`.
- R6: `pf_valid` is 1 while any slot is predicted. `pf_buf`, `pf_ent` and `pf_addr` name the predicted slot with the lowest buffer number, and within that buffer the lowest slot number. A handshake turns that slot to in-flight. Without a handshake the offer holds.
- R7: A fill names a buffer (`fill_buf`) and a slot (`fill_ent`). If that slot is in flight, it becomes ready and stores `fill_data`. A fill aimed at a slot in any other state is ignored.
- R8: A lookup whose address matches a ready slot raises `lk_hit` and returns that slot's line on `lk_data` in the same cycle. The slot is empty from the next cycle on.
- R9: A lookup that matches an in-flight slot, and no ready slot, raises `lk_pend` and leaves `lk_hit` at 0.
- R10: A probe discards every predicted slot whose address equals `probe_addr`. This happens only in a cycle with no prefetch handshake; otherwise the probe has no effect.
- R11: A lookup that matches only predicted slots, or no slot at all, misses: `lk_hit` and `lk_pend` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Allocation request |
| alloc_pc | input | PCW | PC of the load that claims a buffer |
| alloc_addr | input | AW | Last address of that load |
| alloc_stride | input | AW | Stride of that load |
| pred_req_valid | output | 1 | A buffer asks for an address |
| pred_ready | input | 1 | Predictor grants an address this cycle |
| pred_req_buf | output | log2(NBUF) | Requesting buffer |
| pred_req_pc | output | PCW | PC owning the requesting buffer |
| pred_req_last | output | AW | Last address predicted for that buffer |
| pred_req_stride | output | AW | Stride stored for that buffer |
| pred_addr | input | AW | Address returned by the predictor |
| pf_valid | output | 1 | Prefetch request offered |
| pf_ready | input | 1 | Memory accepts the prefetch |
| pf_buf | output | log2(NBUF) | Buffer of the offered prefetch |
| pf_ent | output | log2(DEPTH) | Slot of the offered prefetch |
| pf_addr | output | AW | Address to prefetch |
| fill_valid | input | 1 | Returned line |
| fill_buf | input | log2(NBUF) | Buffer tag of the returned line |
| fill_ent | input | log2(DEPTH) | Slot tag of the returned line |
| fill_data | input | DW | Line data |
| lk_valid | input | 1 | L1 load lookup |
| lk_addr | input | AW | Lookup address |
| lk_hit | output | 1 | Ready slot matched |
| lk_pend | output | 1 | Only an in-flight slot matched |
| lk_data | output | DW | Line of the matched ready slot |
| probe_valid | input | 1 | Probe request |
| probe_addr | input | AW | Address whose predicted slots are dropped |

## Verification
Every slot state can be read at the ports without delay. The request and prefetch offers, and the lookup flags, are decoded from the registered state with no further pipeline stage. So a slot left in the wrong state, or a buffer bound to the wrong owner, shows up as an offer that is wrong, missing or stale. It can show up on the cycle right after the faulty edge, or as soon as a lookup or probe touches that address. The bench drives a small number of buffers through every state transition. It reads the offers after each edge and walks a table of lookups, whose hit and pending results depend on each earlier lookup having freed its slot.

// File: rtl/pdsb_array.sv
`timescale 1ns/1ps
module pdsb_array #(
  parameter int NBUF  = 8,
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PCW   = 16,
  localparam int BW   = $clog2(NBUF),
  localparam int EW   = $clog2(DEPTH)
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_valid,
  input  logic [PCW-1:0] alloc_pc,
  input  logic [AW-1:0]  alloc_addr,
  input  logic [AW-1:0]  alloc_stride,
  output logic           pred_req_valid,
  input  logic           pred_ready,
  output logic [BW-1:0]  pred_req_buf,
  output logic [PCW-1:0] pred_req_pc,
  output logic [AW-1:0]  pred_req_last,
  output logic [AW-1:0]  pred_req_stride,
  input  logic [AW-1:0]  pred_addr,
  output logic           pf_valid,
  input  logic           pf_ready,
  output logic [BW-1:0]  pf_buf,
  output logic [EW-1:0]  pf_ent,
  output logic [AW-1:0]  pf_addr,
  input  logic           fill_valid,
  input  logic [BW-1:0]  fill_buf,
  input  logic [EW-1:0]  fill_ent,
  input  logic [DW-1:0]  fill_data,
  input  logic           lk_valid,
  input  logic [AW-1:0]  lk_addr,
  output logic           lk_hit,
  output logic           lk_pend,
  output logic [DW-1:0]  lk_data,
  input  logic           probe_valid,
  input  logic [AW-1:0]  probe_addr
);

  typedef enum logic [1:0] {E_EMPTY, E_PRED, E_PEND, E_READY} est_t;

  logic [NBUF-1:0] own_q;
  logic [PCW-1:0]  pc_q     [NBUF];
  logic [AW-1:0]   last_q   [NBUF];
  logic [AW-1:0]   stride_q [NBUF];
  est_t            st_q     [NBUF][DEPTH];
  logic [AW-1:0]   addr_q   [NBUF][DEPTH];
  logic [DW-1:0]   data_q   [NBUF][DEPTH];
  logic [BW-1:0]   victim_q;

  logic            dup, free_any, any_pend;
  logic [BW-1:0]   free_b, alloc_b, pr_b;
  logic [EW-1:0]   pr_e;
  logic            rhit [NBUF][DEPTH];
  logic            alloc_fire, pred_fire, pf_fire;

  always_comb begin
    dup      = 1'b0;
    free_any = 1'b0;
    free_b   = '0;
    for (int b = NBUF-1; b >= 0; b--) begin
      if (own_q[b] && pc_q[b] == alloc_pc) dup = 1'b1;
      if (!own_q[b]) begin
        free_any = 1'b1;
        free_b   = BW'(b);
      end
    end
  end

  always_comb begin
    pred_req_valid = 1'b0;
    pr_b = '0;
    pr_e = '0;
    pf_valid = 1'b0;
    pf_buf = '0;
    pf_ent = '0;
    for (int b = NBUF-1; b >= 0; b--)
      for (int e = DEPTH-1; e >= 0; e--) begin
        if (own_q[b] && st_q[b][e] == E_EMPTY) begin
          pred_req_valid = 1'b1;
          pr_b = BW'(b);
          pr_e = EW'(e);
        end
        if (st_q[b][e] == E_PRED) begin
          pf_valid = 1'b1;
          pf_buf = BW'(b);
          pf_ent = EW'(e);
        end
      end
  end

  always_comb begin
    lk_hit   = 1'b0;
    any_pend = 1'b0;
    lk_data  = '0;
    for (int b = NBUF-1; b >= 0; b--)
      for (int e = DEPTH-1; e >= 0; e--) begin
        rhit[b][e] = lk_valid && st_q[b][e] == E_READY && addr_q[b][e] == lk_addr;
        if (rhit[b][e]) begin
          lk_hit  = 1'b1;
          lk_data = data_q[b][e];
        end
        if (lk_valid && st_q[b][e] == E_PEND && addr_q[b][e] == lk_addr) any_pend = 1'b1;
      end
  end

  assign lk_pend         = any_pend && !lk_hit;
  assign pred_req_buf    = pr_b;
  assign pred_req_pc     = pc_q[pr_b];
  assign pred_req_last   = last_q[pr_b];
  assign pred_req_stride = stride_q[pr_b];
  assign pf_addr         = addr_q[pf_buf][pf_ent];

  assign alloc_fire = alloc_valid && !dup;
  assign alloc_b    = free_any ? free_b : victim_q;
  assign pred_fire  = pred_req_valid && pred_ready;
  assign pf_fire    = pf_valid && pf_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      victim_q <= '0;
      own_q    <= '0;
      for (int b = 0; b < NBUF; b++) begin
        pc_q[b]     <= '0;
        last_q[b]   <= '0;
        stride_q[b] <= '0;
        for (int e = 0; e < DEPTH; e++) begin
          st_q[b][e]   <= E_EMPTY;
          addr_q[b][e] <= '0;
          data_q[b][e] <= '0;
        end
      end
    end else begin
      if (alloc_fire && !free_any)
        victim_q <= (victim_q == BW'(NBUF-1)) ? '0 : victim_q + BW'(1);
      for (int b = 0; b < NBUF; b++) begin
        if (alloc_fire && alloc_b == BW'(b)) begin
          own_q[b]    <= 1'b1;
          pc_q[b]     <= alloc_pc;
          last_q[b]   <= alloc_addr;
          stride_q[b] <= alloc_stride;
          for (int e = 0; e < DEPTH; e++) st_q[b][e] <= E_EMPTY;
        end else begin
          if (pred_fire && pr_b == BW'(b)) last_q[b] <= pred_addr;
          for (int e = 0; e < DEPTH; e++) begin
            if (pred_fire && pr_b == BW'(b) && pr_e == EW'(e)) begin
              st_q[b][e]   <= E_PRED;
              addr_q[b][e] <= pred_addr;
            end
            if (pf_fire && pf_buf == BW'(b) && pf_ent == EW'(e)) st_q[b][e] <= E_PEND;
            if (fill_valid && fill_buf == BW'(b) && fill_ent == EW'(e) && st_q[b][e] == E_PEND) begin
              st_q[b][e]   <= E_READY;
              data_q[b][e] <= fill_data;
            end
            if (rhit[b][e]) st_q[b][e] <= E_EMPTY;
            if (probe_valid && !pf_fire && st_q[b][e] == E_PRED && addr_q[b][e] == probe_addr)
              st_q[b][e] <= E_EMPTY;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pdsb_array_chk.sv
`timescale 1ns/1ps
module pdsb_array_chk (
  input logic clk,
  input logic rst_n,
  input logic alloc_valid,
  input logic pred_req_valid,
  input logic pred_ready,
  input logic pf_valid,
  input logic pf_ready,
  input logic probe_valid,
  input logic lk_valid,
  input logic lk_hit
);

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= !rst_n;

  // R1
  always_ff @(posedge clk)
    if (!rst_n && rst_seen) begin
      reset_idle_chk: assert (!pred_req_valid && !pf_valid && !lk_hit)
        else $error("offers or hit active during reset");
    end

  // R5
  pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_req_valid && !pred_ready |=> pred_req_valid);

  // R5
  pred_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_req_valid && pred_ready && !alloc_valid |=> pf_valid);

  // R6
  pf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready && !probe_valid && !alloc_valid |=> pf_valid);

  // R8
  hit_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_hit && !alloc_valid |=> pred_req_valid);

endmodule

bind pdsb_array pdsb_array_chk i_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
  .pred_req_valid(pred_req_valid), .pred_ready(pred_ready),
  .pf_valid(pf_valid), .pf_ready(pf_ready), .probe_valid(probe_valid),
  .lk_valid(lk_valid), .lk_hit(lk_hit)
);

// File: tb/test_pdsb_array.sv
`timescale 1ns/1ps
module test_pdsb_array;
  localparam int NBUF = 8, DEPTH = 4, AW = 32, DW = 32, PCW = 16;
  localparam int BW = $clog2(NBUF), EW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0; logic [PCW-1:0] alloc_pc = '0;
  logic [AW-1:0] alloc_addr = '0, alloc_stride = '0;
  logic pred_req_valid, pred_ready = 0;
  logic [BW-1:0] pred_req_buf; logic [PCW-1:0] pred_req_pc;
  logic [AW-1:0] pred_req_last, pred_req_stride, pred_addr;
  logic pf_valid, pf_ready = 0; logic [BW-1:0] pf_buf; logic [EW-1:0] pf_ent; logic [AW-1:0] pf_addr;
  logic fill_valid = 0; logic [BW-1:0] fill_buf = '0; logic [EW-1:0] fill_ent = '0; logic [DW-1:0] fill_data = '0;
  logic lk_valid = 0; logic [AW-1:0] lk_addr = '0; logic lk_hit, lk_pend; logic [DW-1:0] lk_data;
  logic probe_valid = 0; logic [AW-1:0] probe_addr = '0;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  // predictor model: next address is last plus stride
  assign pred_addr = pred_req_last + pred_req_stride;

  pdsb_array #(.NBUF(NBUF), .DEPTH(DEPTH), .AW(AW), .DW(DW), .PCW(PCW)) i_pdsb_array (.*);

  function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic go();
    @(posedge clk); #1;
  endtask

  task automatic alloc(input logic [PCW-1:0] pc, input logic [AW-1:0] a, input logic [AW-1:0] s);
    alloc_valid = 1; alloc_pc = pc; alloc_addr = a; alloc_stride = s;
    go();
    alloc_valid = 0;
  endtask

  task automatic fill(input int b, input int e, input logic [DW-1:0] d);
    fill_valid = 1; fill_buf = BW'(b); fill_ent = EW'(e); fill_data = d;
    go();
    fill_valid = 0;
  endtask

  task automatic look(input logic [AW-1:0] a);
    lk_valid = 1; lk_addr = a; #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // lookup table: {address, expected hit, expected pending}
  localparam logic [33:0] LKV [8] = '{
    {32'h5008, 1'b1, 1'b0},
    {32'h5008, 1'b0, 1'b0},
    {32'h5010, 1'b0, 1'b1},
    {32'h5018, 1'b1, 1'b0},
    {32'h5020, 1'b0, 1'b0},
    {32'h5010, 1'b0, 1'b1},
    {32'h7000, 1'b0, 1'b0},
    {32'h5018, 1'b0, 1'b0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) go();
    chk("R1", "pred_req_valid in reset", pred_req_valid, 0);
    chk("R1", "pf_valid in reset", pf_valid, 0);
    rst_n = 1;
    go();
    look(32'h0);
    chk("R1", "lk_hit after reset", lk_hit, 0);
    chk("R1", "lk_pend after reset", lk_pend, 0);
    chk("R1", "pred_req_valid after reset", pred_req_valid, 0);
    lk_valid = 0;

    alloc(16'h10, 32'h1000, 32'h40);
    chk("R2", "pred_req_valid", pred_req_valid, 1);
    chk("R2", "pred_req_buf", pred_req_buf, 0);
    chk("R2", "pred_req_pc", pred_req_pc, 16'h10);
    chk("R2", "pred_req_last", pred_req_last, 32'h1000);
    chk("R2", "pred_req_stride", pred_req_stride, 32'h40);

    alloc(16'h10, 32'h9000, 32'h8);
    chk("R3", "last kept", pred_req_last, 32'h1000);
    chk("R3", "stride kept", pred_req_stride, 32'h40);

    pred_ready = 1;
    for (int i = 0; i < 4; i++) begin
      chk("R5", "pred_req_last step", pred_req_last, 32'h1000 + i * 32'h40);
      go();
    end
    pred_ready = 0;
    chk("R5", "no empty slot left", pred_req_valid, 0);
    chk("R6", "pf_valid", pf_valid, 1);
    chk("R6", "pf_addr first", pf_addr, 32'h1040);
    chk("R6", "pf_ent first", pf_ent, 0);
    chk("R6", "pf_buf first", pf_buf, 0);

    pf_ready = 1; go(); pf_ready = 0;
    chk("R6", "pf_addr after handshake", pf_addr, 32'h1080);
    chk("R6", "pf_ent after handshake", pf_ent, 1);
    go();
    chk("R6", "pf_addr held on stall", pf_addr, 32'h1080);

    look(32'h1040);
    chk("R9", "in-flight lk_pend", lk_pend, 1);
    chk("R9", "in-flight lk_hit", lk_hit, 0);
    look(32'h1080);
    chk("R11", "predicted lk_hit", lk_hit, 0);
    chk("R11", "predicted lk_pend", lk_pend, 0);
    lk_valid = 0;

    fill(0, 1, 32'hDEAD_BEEF);
    look(32'h1080);
    chk("R7", "fill to predicted slot lk_hit", lk_hit, 0);
    lk_valid = 0;
    chk("R7", "fill to predicted slot pf_addr", pf_addr, 32'h1080);

    fill(0, 0, line_of(32'h1040));
    look(32'h1040);
    chk("R7", "filled slot lk_hit", lk_hit, 1);
    chk("R8", "lk_data", lk_data, line_of(32'h1040));
    go();
    look(32'h1040);
    chk("R8", "freed slot misses", lk_hit, 0);
    lk_valid = 0;
    chk("R8", "freed slot requests", pred_req_valid, 1);
    chk("R8", "request last", pred_req_last, 32'h1100);

    probe_valid = 1; probe_addr = 32'h10C0; pf_ready = 1;
    go();
    probe_valid = 0; pf_ready = 0;
    chk("R10", "probe blocked by handshake", pf_addr, 32'h10C0);
    probe_valid = 1;
    go();
    probe_valid = 0;
    chk("R10", "probe dropped slot", pf_addr, 32'h1100);
    chk("R10", "probe dropped slot ent", pf_ent, 3);

    for (int i = 1; i < 8; i++) alloc(PCW'(16'h20 + i), 32'h2000 * i, 32'h4);
    chk("R4", "buffer 0 still owner 10", pred_req_pc, 16'h10);
    look(32'h1080);
    chk("R4", "in-flight before victim", lk_pend, 1);
    lk_valid = 0;
    alloc(16'h30, 32'h5000, 32'h8);
    chk("R4", "victim 0 pc", pred_req_pc, 16'h30);
    chk("R4", "victim 0 last", pred_req_last, 32'h5000);
    chk("R4", "victim predicted cleared", pf_valid, 0);
    look(32'h1080);
    chk("R4", "victim in-flight cleared", lk_pend, 0);
    lk_valid = 0;
    alloc(16'h31, 32'h6000, 32'h8);
    pred_ready = 1;
    repeat (4) go();
    pred_ready = 0;
    chk("R4", "second victim buf", pred_req_buf, 1);
    chk("R4", "second victim pc", pred_req_pc, 16'h31);
    chk("R4", "second victim last", pred_req_last, 32'h6000);

    pf_ready = 1;
    repeat (3) go();
    pf_ready = 0;
    chk("R6", "fourth offer", pf_addr, 32'h5020);
    fill(0, 0, line_of(32'h5008));
    fill(0, 2, line_of(32'h5018));

    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a;
      logic eh, ep;
      string tag;
      {a, eh, ep} = LKV[i];
      tag = eh ? "R8" : (ep ? "R9" : "R11");
      look(a);
      chk(tag, "table lk_hit", lk_hit, eh);
      chk(tag, "table lk_pend", lk_pend, ep);
      if (eh) chk(tag, "table lk_data", lk_data, line_of(a));
      go();
    end
    lk_valid = 0;

    summary();
    $finish;
  end
endmodule